// File: doc/BRIEF.md
# Multi-Class Register Rename Table

This block translates architectural register numbers into physical register numbers for an out-of-order core. It keeps one map table and one free list for each of three renamed register classes: integer, floating-point and condition-code. Every operation carries a three-bit class tag, and that tag steers the operation to the table of its class. A rename request reports the mapping it replaces together with a freshly allocated physical register. A lookup reads the current mapping. A set-entry overwrite lets commit and squash logic put a mapping back. A return port hands freed physical registers back to the free list of their class.

The integer and floating-point classes each have a hardwired zero register, whose index is set by a parameter. Renaming that register allocates nothing. The condition-code class has no such register. The miscellaneous class is never renamed: its physical number is always its architectural number, and writes to it leave all state unchanged. A mismatching write to it raises a flag. An unknown class tag raises an error flag and has no effect on state.

Top module: `rename_table`

## Requirements
- R1: After reset, every map entry of the integer (tag 0), floating-point (tag 1) and condition-code (tag 2) classes holds its own index, so a lookup of index i returns i.
- R2: After reset, each class free list holds the physical numbers NARCH up to NPHYS-1. Successive allocating renames of one class return them in ascending order.
- R3: A rename with ren_valid reports the current mapping on ren_prev and the allocated register on ren_new in the same cycle. From the next cycle on, the map entry holds ren_new.
- R4: A rename of index INT_ZERO in the integer class, or of index FP_ZERO in the floating-point class, returns that index on ren_new, reports the current mapping on ren_prev, and takes nothing from the free list.
- R5: The condition-code class has no zero register, so a rename of any of its indices, index 0 included, allocates from its free list.
- R6: The three class tables and their free lists are independent. An operation on one class changes no mapping and no free-list content of another class.
- R7: A set-entry with set_valid on tag 0, 1 or 2 writes set_phys into that class's entry set_arch. A lookup in the following cycle returns set_phys.
- R8: The miscellaneous class (tag 3) is fixed. Its rename and lookup return the architectural index, and a rename on it never stalls. A set-entry on it changes no state, and err_misc is high in the same cycle exactly when set_phys differs from set_arch.
- R9: Tags 4 to 7 are unknown. Any valid rename, lookup, set-entry or return carrying one drives err_class high in the same cycle, changes no state, and returns 0 on ren_new, ren_prev and lk_phys.
- R10: When the target class's free list is empty, an allocating rename drives ren_stall high and ren_new and ren_prev to 0. The map entry and the free list stay unchanged.
- R11: A return with ret_valid appends ret_phys to the tail of its class free list. The returned register is handed out only after the entries already queued.
- R12: A lookup in the same cycle as a rename of the same entry returns the mapping held before that rename.
- R13: When a rename and a set-entry target the same entry in the same cycle, the set-entry value is the one the entry holds afterwards. The rename still consumes its free register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ren_valid | input | 1 | Rename request |
| ren_class | input | 3 | Rename class tag |
| ren_arch | input | AW | Architectural index to rename |
| ren_new | output | PW | Newly assigned physical register |
| ren_prev | output | PW | Mapping replaced by the rename |
| ren_stall | output | 1 | Free list empty, rename not performed |
| lk_valid | input | 1 | Lookup request (qualifies the error flag) |
| lk_class | input | 3 | Lookup class tag |
| lk_arch | input | AW | Architectural index to look up |
| lk_phys | output | PW | Current mapping |
| set_valid | input | 1 | Set-entry request |
| set_class | input | 3 | Set-entry class tag |
| set_arch | input | AW | Entry to overwrite |
| set_phys | input | PW | Value to write |
| ret_valid | input | 1 | Free-register return |
| ret_class | input | 3 | Return class tag |
| ret_phys | input | PW | Physical register being freed |
| err_class | output | 1 | Unknown class tag on a valid operation |
| err_misc | output | 1 | Miscellaneous set-entry value differs from the fixed mapping |

## Verification
The rename results, the lookup value and both flags are combinational. Each is due in the same cycle as its stimulus, before the next rising edge. Map and free-list updates take effect at that edge, so they first show up in the cycle after it. The bench drives every operation on the falling edge and samples the combinational results 1 ns later. Its reference model advances only after that sample. A state change is therefore checked by a later lookup or rename, never by the operation that caused it.

// File: rtl/rn_pkg.sv
package rn_pkg;
    typedef enum logic [2:0] {
        CLS_INT  = 3'd0,
        CLS_FP   = 3'd1,
        CLS_CC   = 3'd2,
        CLS_MISC = 3'd3
    } rn_class_e;

    localparam int NUM_TABLES = 3;

    function automatic logic cls_known(input logic [2:0] c);
        return c <= 3'd3;
    endfunction

    function automatic logic cls_renamed(input logic [2:0] c);
        return c < 3'd3;
    endfunction
endpackage

// File: rtl/rn_freelist.sv
module rn_freelist #(
    parameter int NPHYS = 16,
    parameter int NARCH = 8,
    parameter int PW    = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pop,
    input  logic          push,
    input  logic [PW-1:0] push_val,
    output logic [PW-1:0] head,
    output logic          empty
);
    localparam int INIT_FILL = NPHYS - NARCH;

    logic [PW-1:0] slots [NPHYS];
    logic [PW-1:0] rd_ptr, wr_ptr;
    logic [PW:0]   fill;
    logic          do_pop, do_push;

    assign empty   = (fill == '0);
    assign head    = slots[rd_ptr];
    assign do_pop  = pop && !empty;
    assign do_push = push && ((fill < (PW+1)'(NPHYS)) || do_pop);

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NPHYS; i++)
                slots[i] <= (i < INIT_FILL) ? PW'(i + NARCH) : '0;
            rd_ptr <= '0;
            wr_ptr <= PW'(INIT_FILL);
            fill   <= (PW+1)'(INIT_FILL);
        end else begin
            if (do_push) begin
                slots[wr_ptr] <= push_val;
                wr_ptr        <= wr_ptr + 1'b1;
            end
            if (do_pop)
                rd_ptr <= rd_ptr + 1'b1;
            case ({do_push, do_pop})
                2'b10:   fill <= fill + 1'b1;
                2'b01:   fill <= fill - 1'b1;
                default: fill <= fill;
            endcase
        end
    end
endmodule

// File: rtl/rn_maptable.sv
module rn_maptable #(
    parameter int NARCH = 8,
    parameter int AW    = $clog2(NARCH),
    parameter int PW    = 4
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ren_we,
    input  logic [AW-1:0] ren_idx,
    input  logic [PW-1:0] ren_val,
    input  logic          set_we,
    input  logic [AW-1:0] set_idx,
    input  logic [PW-1:0] set_val,
    input  logic [AW-1:0] rd_a_idx,
    input  logic [AW-1:0] rd_b_idx,
    output logic [PW-1:0] rd_a,
    output logic [PW-1:0] rd_b
);
    logic [PW-1:0] entry [NARCH];

    assign rd_a = entry[rd_a_idx];
    assign rd_b = entry[rd_b_idx];

    always_ff @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < NARCH; i++)
                entry[i] <= PW'(i);
        end else begin
            if (ren_we)
                entry[ren_idx] <= ren_val;
            // restore from commit/squash overrides a same-cycle rename
            if (set_we)
                entry[set_idx] <= set_val;
        end
    end
endmodule

// File: rtl/rename_table.sv
module rename_table
    import rn_pkg::*;
#(
    parameter int NARCH    = 8,
    parameter int NPHYS    = 16,
    parameter int INT_ZERO = 0,
    parameter int FP_ZERO  = 7,
    parameter int AW       = $clog2(NARCH),
    parameter int PW       = $clog2(NPHYS)
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ren_valid,
    input  logic [2:0]    ren_class,
    input  logic [AW-1:0] ren_arch,
    output logic [PW-1:0] ren_new,
    output logic [PW-1:0] ren_prev,
    output logic          ren_stall,
    input  logic          lk_valid,
    input  logic [2:0]    lk_class,
    input  logic [AW-1:0] lk_arch,
    output logic [PW-1:0] lk_phys,
    input  logic          set_valid,
    input  logic [2:0]    set_class,
    input  logic [AW-1:0] set_arch,
    input  logic [PW-1:0] set_phys,
    input  logic          ret_valid,
    input  logic [2:0]    ret_class,
    input  logic [PW-1:0] ret_phys,
    output logic          err_class,
    output logic          err_misc
);
    logic [NUM_TABLES-1:0] stall_v;
    logic [PW-1:0]         new_v  [NUM_TABLES];
    logic [PW-1:0]         prev_v [NUM_TABLES];
    logic [PW-1:0]         lk_v   [NUM_TABLES];

    for (genvar c = 0; c < NUM_TABLES; c++) begin : g_cls
        localparam bit HAS_ZERO = (c != int'(CLS_CC));
        localparam int ZIDX     = (c == int'(CLS_INT)) ? INT_ZERO : FP_ZERO;

        logic          sel_ren, zero_hit, want, pop, empty;
        logic [PW-1:0] head;

        assign sel_ren  = ren_valid && (ren_class == 3'(c));
        assign zero_hit = HAS_ZERO && (ren_arch == AW'(ZIDX));
        assign want     = sel_ren && !zero_hit;
        assign pop      = want && !empty;
        assign stall_v[c] = want && empty;
        assign new_v[c]   = zero_hit ? PW'(ZIDX) : head;

        rn_freelist #(.NPHYS(NPHYS), .NARCH(NARCH), .PW(PW)) u_free (
            .clk     (clk),
            .rst     (rst),
            .pop     (pop),
            .push    (ret_valid && (ret_class == 3'(c))),
            .push_val(ret_phys),
            .head    (head),
            .empty   (empty)
        );

        rn_maptable #(.NARCH(NARCH), .AW(AW), .PW(PW)) u_map (
            .clk     (clk),
            .rst     (rst),
            .ren_we  (pop),
            .ren_idx (ren_arch),
            .ren_val (head),
            .set_we  (set_valid && (set_class == 3'(c))),
            .set_idx (set_arch),
            .set_val (set_phys),
            .rd_a_idx(ren_arch),
            .rd_b_idx(lk_arch),
            .rd_a    (prev_v[c]),
            .rd_b    (lk_v[c])
        );
    end

    always_comb begin
        ren_new   = '0;
        ren_prev  = '0;
        ren_stall = 1'b0;
        if (ren_valid) begin
            case (ren_class)
                CLS_INT, CLS_FP, CLS_CC: begin
                    ren_stall = stall_v[ren_class[1:0]];
                    if (!ren_stall) begin
                        ren_new  = new_v[ren_class[1:0]];
                        ren_prev = prev_v[ren_class[1:0]];
                    end
                end
                CLS_MISC: begin
                    ren_new  = PW'(ren_arch);
                    ren_prev = PW'(ren_arch);
                end
                default: ;
            endcase
        end
    end

    always_comb begin
        case (lk_class)
            CLS_INT, CLS_FP, CLS_CC: lk_phys = lk_v[lk_class[1:0]];
            CLS_MISC:                lk_phys = PW'(lk_arch);
            default:                 lk_phys = '0;
        endcase
    end

    assign err_class = (ren_valid && !cls_known(ren_class)) ||
                       (lk_valid  && !cls_known(lk_class))  ||
                       (set_valid && !cls_known(set_class)) ||
                       (ret_valid && !cls_known(ret_class));

    assign err_misc = set_valid && (set_class == CLS_MISC) &&
                      (set_phys != PW'(set_arch));
endmodule

// File: rtl/rename_table_chk.sv
module rename_table_chk #(
    parameter int AW       = 3,
    parameter int PW       = 4,
    parameter int INT_ZERO = 0,
    parameter int FP_ZERO  = 7
) (
    input logic          clk,
    input logic          rst,
    input logic          ren_valid,
    input logic [2:0]    ren_class,
    input logic [AW-1:0] ren_arch,
    input logic [PW-1:0] ren_new,
    input logic [PW-1:0] ren_prev,
    input logic          ren_stall,
    input logic          set_valid,
    input logic [2:0]    set_class,
    input logic [AW-1:0] set_arch,
    input logic [PW-1:0] set_phys,
    input logic          err_class,
    input logic          err_misc
);
    assert_misc_fixed_R8: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_class == 3'd3) |->
            (ren_new == PW'(ren_arch) && ren_prev == PW'(ren_arch) && !ren_stall));

    assert_misc_mismatch_R8: assert property (@(posedge clk) disable iff (rst)
        (set_valid && set_class == 3'd3 && set_phys != PW'(set_arch)) |-> err_misc);

    assert_zero_int_R4: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_class == 3'd0 && ren_arch == AW'(INT_ZERO)) |->
            (ren_new == PW'(INT_ZERO) && !ren_stall));

    assert_zero_fp_R4: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_class == 3'd1 && ren_arch == AW'(FP_ZERO)) |->
            (ren_new == PW'(FP_ZERO) && !ren_stall));

    assert_unknown_tag_R9: assert property (@(posedge clk) disable iff (rst)
        (ren_valid && ren_class > 3'd3) |->
            (err_class && ren_new == '0 && ren_prev == '0 && !ren_stall));

    assert_stall_renamed_only_R10: assert property (@(posedge clk) disable iff (rst)
        ren_stall |-> (ren_valid && ren_class < 3'd3 && ren_new == '0));
endmodule

bind rename_table rename_table_chk #(
    .AW(AW), .PW(PW), .INT_ZERO(INT_ZERO), .FP_ZERO(FP_ZERO)
) chk_i (
    .clk      (clk),
    .rst      (rst),
    .ren_valid(ren_valid),
    .ren_class(ren_class),
    .ren_arch (ren_arch),
    .ren_new  (ren_new),
    .ren_prev (ren_prev),
    .ren_stall(ren_stall),
    .set_valid(set_valid),
    .set_class(set_class),
    .set_arch (set_arch),
    .set_phys (set_phys),
    .err_class(err_class),
    .err_misc (err_misc)
);

// File: tb/rename_table_tb_top.sv
`timescale 1ns/1ps
module rename_table_tb_top;
    localparam int NARCH = 8;
    localparam int NPHYS = 16;
    localparam int AW = 3;
    localparam int PW = 4;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ren_valid = 0, lk_valid = 0, set_valid = 0, ret_valid = 0;
    logic [2:0] ren_class = 0, lk_class = 0, set_class = 0, ret_class = 0;
    logic [AW-1:0] ren_arch = 0, lk_arch = 0, set_arch = 0;
    logic [PW-1:0] set_phys = 0, ret_phys = 0;
    logic [PW-1:0] ren_new, ren_prev, lk_phys;
    logic ren_stall, err_class, err_misc;

    always #10 clk = ~clk;

    rename_table dut_i (
        .clk(clk), .rst(rst),
        .ren_valid(ren_valid), .ren_class(ren_class), .ren_arch(ren_arch),
        .ren_new(ren_new), .ren_prev(ren_prev), .ren_stall(ren_stall),
        .lk_valid(lk_valid), .lk_class(lk_class), .lk_arch(lk_arch), .lk_phys(lk_phys),
        .set_valid(set_valid), .set_class(set_class), .set_arch(set_arch), .set_phys(set_phys),
        .ret_valid(ret_valid), .ret_class(ret_class), .ret_phys(ret_phys),
        .err_class(err_class), .err_misc(err_misc)
    );

    int checks = 0;
    int errors = 0;
    bit done = 0;

    // reference model
    int mm [3][NARCH];
    int fq [3][NPHYS];
    int fh [3];
    int fc [3];

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    task automatic model_reset();
        for (int c = 0; c < 3; c++) begin
            for (int i = 0; i < NARCH; i++) mm[c][i] = i;
            for (int k = 0; k < NPHYS; k++) fq[c][k] = (k < NPHYS - NARCH) ? NARCH + k : 0;
            fh[c] = 0;
            fc[c] = NPHYS - NARCH;
        end
    endtask

    task automatic idle();
        ren_valid = 0; lk_valid = 0; set_valid = 0; ret_valid = 0;
    endtask

    function automatic bit zero_hit(input int c, input int a);
        return (c == 0 && a == 0) || (c == 1 && a == 7);
    endfunction

    task automatic t_rename(input int c, input int a, input string tag);
        int en, ep, es, ee;
        @(negedge clk);
        idle();
        ren_valid = 1; ren_class = 3'(c); ren_arch = AW'(a);
        lk_valid = 1;  lk_class = 3'(c);  lk_arch = AW'(a);
        #1;
        en = 0; ep = 0; es = 0; ee = 0;
        if (c == 3) begin en = a; ep = a; end
        else if (c > 3) ee = 1;
        else if (zero_hit(c, a)) begin en = a; ep = mm[c][a]; end
        else if (fc[c] == 0) es = 1;
        else begin en = fq[c][fh[c]]; ep = mm[c][a]; end
        chk({tag, " ren_new"}, int'(ren_new), en);
        chk({tag, " ren_prev"}, int'(ren_prev), ep);
        chk({tag, " ren_stall"}, int'(ren_stall), es);
        chk({tag, " err_class"}, int'(err_class), ee);
        if (c < 3) chk({tag, " same-cycle lookup R12"}, int'(lk_phys), mm[c][a]);
        if (c < 3 && !zero_hit(c, a) && fc[c] > 0) begin
            mm[c][a] = fq[c][fh[c]];
            fh[c] = (fh[c] + 1) % NPHYS;
            fc[c]--;
        end
    endtask

    task automatic t_lookup(input int c, input int a, input string tag);
        int ex;
        @(negedge clk);
        idle();
        lk_valid = 1; lk_class = 3'(c); lk_arch = AW'(a);
        #1;
        ex = (c < 3) ? mm[c][a] : ((c == 3) ? a : 0);
        chk({tag, " lk_phys"}, int'(lk_phys), ex);
        chk({tag, " err_class"}, int'(err_class), (c > 3) ? 1 : 0);
    endtask

    task automatic t_set(input int c, input int a, input int p, input string tag);
        @(negedge clk);
        idle();
        set_valid = 1; set_class = 3'(c); set_arch = AW'(a); set_phys = PW'(p);
        #1;
        chk({tag, " err_misc"}, int'(err_misc), (c == 3 && p != a) ? 1 : 0);
        chk({tag, " err_class"}, int'(err_class), (c > 3) ? 1 : 0);
        if (c < 3) mm[c][a] = p;
    endtask

    task automatic t_ret(input int c, input int p, input string tag);
        @(negedge clk);
        idle();
        ret_valid = 1; ret_class = 3'(c); ret_phys = PW'(p);
        #1;
        chk({tag, " err_class"}, int'(err_class), (c > 3) ? 1 : 0);
        if (c < 3 && fc[c] < NPHYS) begin
            fq[c][(fh[c] + fc[c]) % NPHYS] = p;
            fc[c]++;
        end
    endtask

    // rename and set-entry on the same entry in one cycle
    task automatic t_collide(input int c, input int a, input int p, input string tag);
        @(negedge clk);
        idle();
        ren_valid = 1; ren_class = 3'(c); ren_arch = AW'(a);
        set_valid = 1; set_class = 3'(c); set_arch = AW'(a); set_phys = PW'(p);
        #1;
        chk({tag, " ren_new"}, int'(ren_new), fq[c][fh[c]]);
        fh[c] = (fh[c] + 1) % NPHYS;
        fc[c]--;
        mm[c][a] = p;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    initial begin
        model_reset();
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;
        #1;
        chk("R1 reset ren_stall", int'(ren_stall), 0);
        chk("R1 reset err_class", int'(err_class), 0);
        chk("R1 reset err_misc", int'(err_misc), 0);

        // R1 identity after reset, R8 misc identity: sweep all classes
        for (int c = 0; c < 4; c++)
            for (int a = 0; a < NARCH; a++)
                t_lookup(c, a, (c == 3) ? "R8 misc lookup" : "R1 reset map");

        // R2/R3/R12 integer renames in ascending allocation order
        for (int a = 1; a < NARCH; a++) t_rename(0, a, "R2 R3 int rename");
        for (int a = 1; a < NARCH; a++) t_lookup(0, a, "R3 int map updated");

        // R4 zero registers allocate nothing
        t_rename(0, 0, "R4 int zero");
        t_rename(1, 7, "R4 fp zero");
        // R6 fp free list untouched by integer renames
        t_rename(1, 0, "R6 fp independent");
        t_lookup(1, 3, "R6 fp map untouched");
        t_lookup(2, 5, "R6 cc map untouched");

        // R5 condition-code index 0 allocates; then drain cc list
        t_rename(2, 0, "R5 cc index 0");
        for (int a = 1; a < NARCH; a++) t_rename(2, a, "R2 cc sweep");
        t_rename(2, 3, "R10 cc empty");
        t_lookup(2, 3, "R10 cc map unchanged");

        // R10 integer list exhaustion
        t_rename(0, 1, "R2 int last");
        t_rename(0, 2, "R10 int empty");
        t_lookup(0, 2, "R10 int map unchanged");
        t_rename(0, 0, "R4 int zero while empty");

        // R11 returns are queued in order
        t_ret(0, 3, "R11 return");
        t_ret(0, 5, "R11 return");
        t_rename(0, 3, "R11 reuse first");
        t_rename(0, 4, "R11 reuse second");
        t_rename(0, 5, "R10 int empty again");

        // R7 set-entry writes, R8 misc writes ignored
        t_set(0, 6, 12, "R7 set int");
        t_lookup(0, 6, "R7 set visible");
        t_set(2, 1, 2, "R7 set cc");
        t_lookup(2, 1, "R7 set cc visible");
        t_set(3, 4, 9, "R8 misc mismatch");
        t_lookup(3, 4, "R8 misc unchanged");
        t_set(3, 2, 2, "R8 misc match");

        // R9 unknown tags change nothing
        for (int c = 4; c < 8; c++) begin
            t_rename(c, 1, "R9 unknown rename");
            t_lookup(c, 1, "R9 unknown lookup");
            t_set(c, 6, 1, "R9 unknown set");
            t_ret(c, 9, "R9 unknown return");
        end
        t_lookup(0, 6, "R9 int map unchanged");
        t_rename(1, 1, "R9 fp list unchanged");

        // R13 set wins over rename on the same entry
        t_collide(1, 2, 3, "R13 collide");
        t_lookup(1, 2, "R13 set wins");
        t_rename(1, 4, "R13 list advanced");

        @(negedge clk);
        idle();
        done = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule